// File: doc/BRIEF.md
# Predicated SIMD Lane ALU

This block is a 128-bit vector execution unit that treats each operand as eight independent 16-bit unsigned lanes. It performs lane-wise wrapping add and subtract, an unsigned greater-or-equal compare that produces a full-lane mask, and two bitwise merge operations. Each merge copies bits from one source into the prior destination value under a mask operand.

Every lane keeps a one-bit predicate flag beside it. A compare writes its per-lane outcome into that flag, so no vector register is needed to hold the condition. Every operation carries a 2-bit condition code. For each lane, that code decides whether the computed result is written back. All lanes always compute. The condition only drives the per-lane write enables, so timing never depends on which lanes are enabled.

The unit accepts one operation per cycle. The result and write enables appear two clock edges after the operation is presented.

Top module: `simd_pred_alu`

## Requirements
- R1: Opcode 000 (add) gives, in each 16-bit lane i (bits 16i+15..16i), (A+B) mod 2^16. No carry crosses a lane boundary.
- R2: Opcode 001 (subtract) gives, in each lane, (A-B) mod 2^16. No borrow crosses a lane boundary.
- R3: Opcode 010 (compare) gives 16'hFFFF in each lane where A >= B as unsigned values, and 16'h0000 in every other lane.
- R4: Opcode 011 (insert where mask set) gives (A & B) | (D & ~B). B is the mask and D is the prior destination value.
- R5: Opcode 100 (insert where mask clear) gives (A & ~B) | (D & B).
- R6: Each lane has a predicate flag that resets to 0. Only a compare whose condition passes in that lane updates the flag, and the new value is 1 when A >= B in that lane. No other opcode changes any flag.
- R7: The condition code works per lane. Code 00 passes when the lane flag is 0, code 01 passes when it is 1, and codes 10 and 11 always pass. Bit i of lane_we_o is 1 only when lane i passes for a valid, defined opcode.
- R8: The result, valid and write enables appear exactly two rising edges after op_valid_i is sampled high. A new operation may be issued every cycle, and each operation sees the flags left by the one issued before it.
- R9: Opcodes 101, 110 and 111 assert no write enable, produce a zero result and leave the flags unchanged.
- R10: After reset, res_valid_o and lane_we_o are 0 and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Operation present this cycle |
| op_code_i | input | 3 | Operation select |
| cond_i | input | 2 | Per-lane write-back condition |
| src_a_i | input | 128 | First source operand A |
| src_b_i | input | 128 | Second source B, or the mask for the insert operations |
| dst_i | input | 128 | Prior destination value D, used by the insert operations |
| res_valid_o | output | 1 | Result valid |
| res_o | output | 128 | Lane results |
| lane_we_o | output | 8 | Per-lane write enable |

## Verification
The bench builds the unit with its default parameters, eight lanes of sixteen bits. At that width, lane-boundary wrap on add and subtract is easy to provoke with 16'hFFFF and 16'h0000 patterns. Mixed compare outcomes across lanes set flag patterns that differ from lane to lane. Those patterns can then be read back through the write enables of later predicated operations. Back-to-back issue shows that a compare's flags govern the operation issued in the very next cycle.

// File: rtl/simd_pred_pkg.sv
package simd_pred_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'b000,
    OP_SUB   = 3'b001,
    OP_CMPGE = 3'b010,
    OP_INS_T = 3'b011,
    OP_INS_F = 3'b100
  } alu_op_e;

  localparam logic [1:0] COND_FLAG0  = 2'b00;
  localparam logic [1:0] COND_FLAG1  = 2'b01;

  function automatic logic op_is_legal(input logic [2:0] op);
    return (op <= 3'(OP_INS_F));
  endfunction

endpackage

// File: rtl/simd_issue_reg.sv
module simd_issue_reg #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic [1:0]       cond_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic [VEC_W-1:0] d_i,
  output logic             valid_o,
  output logic [2:0]       op_o,
  output logic [1:0]       cond_o,
  output logic [VEC_W-1:0] a_o,
  output logic [VEC_W-1:0] b_o,
  output logic [VEC_W-1:0] d_o
);

  always_ff @(posedge clk) begin
    if (rst) valid_o <= 1'b0;
    else     valid_o <= valid_i;
  end

  // Data path registers carry no reset.
  always_ff @(posedge clk) begin
    op_o   <= op_i;
    cond_o <= cond_i;
    a_o    <= a_i;
    b_o    <= b_i;
    d_o    <= d_i;
  end

endmodule

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
  import simd_pred_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic [2:0]        op_i,
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  logic [LANE_W-1:0] d_i,
  output logic [LANE_W-1:0] res_o,
  output logic              ge_o
);

  logic [LANE_W-1:0] sum_w;
  logic [LANE_W-1:0] diff_w;

  assign sum_w  = a_i + b_i;
  assign diff_w = a_i - b_i;
  assign ge_o   = (a_i >= b_i);

  always_comb begin
    case (op_i)
      3'(OP_ADD):   res_o = sum_w;
      3'(OP_SUB):   res_o = diff_w;
      3'(OP_CMPGE): res_o = {LANE_W{ge_o}};
      3'(OP_INS_T): res_o = (a_i & b_i) | (d_i & ~b_i);
      3'(OP_INS_F): res_o = (a_i & ~b_i) | (d_i & b_i);
      default:      res_o = '0;
    endcase
  end

endmodule

// File: rtl/simd_lane_gate.sv
module simd_lane_gate
  import simd_pred_pkg::*;
(
  input  logic [1:0] cond_i,
  input  logic       flag_i,
  input  logic       legal_i,
  output logic       pass_o
);

  logic cond_ok;

  always_comb begin
    if (cond_i[1])                cond_ok = 1'b1;
    else if (cond_i == COND_FLAG1) cond_ok = flag_i;
    else                          cond_ok = ~flag_i;
  end

  assign pass_o = legal_i & cond_ok;

endmodule

// File: rtl/simd_flag_bank.sv
module simd_flag_bank #(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] upd_en_i,
  input  logic [LANES-1:0] upd_val_i,
  output logic [LANES-1:0] flags_o
);

  for (genvar i = 0; i < LANES; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)              flags_o[i] <= 1'b0;
      else if (upd_en_i[i]) flags_o[i] <= upd_val_i[i];
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
      !upd_en_i[i] |=> $stable(flags_o[i])); // R6
  end

endmodule

// File: rtl/simd_pred_alu.sv
module simd_pred_alu
  import simd_pred_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int LANE_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      op_valid_i,
  input  logic [2:0]                op_code_i,
  input  logic [1:0]                cond_i,
  input  logic [LANES*LANE_W-1:0]   src_a_i,
  input  logic [LANES*LANE_W-1:0]   src_b_i,
  input  logic [LANES*LANE_W-1:0]   dst_i,
  output logic                      res_valid_o,
  output logic [LANES*LANE_W-1:0]   res_o,
  output logic [LANES-1:0]          lane_we_o
);

  localparam int VEC_W = LANES * LANE_W;

  logic             s1_valid;
  logic [2:0]       s1_op;
  logic [1:0]       s1_cond;
  logic [VEC_W-1:0] s1_a, s1_b, s1_d;

  logic [VEC_W-1:0] lane_res;
  logic [LANES-1:0] lane_ge;
  logic [LANES-1:0] lane_pass;
  logic [LANES-1:0] flags;
  logic [LANES-1:0] flag_upd;
  logic             s1_legal;
  logic             s1_is_cmp;

  simd_issue_reg #(.VEC_W(VEC_W)) u_issue (
    .clk(clk), .rst(rst),
    .valid_i(op_valid_i), .op_i(op_code_i), .cond_i(cond_i),
    .a_i(src_a_i), .b_i(src_b_i), .d_i(dst_i),
    .valid_o(s1_valid), .op_o(s1_op), .cond_o(s1_cond),
    .a_o(s1_a), .b_o(s1_b), .d_o(s1_d)
  );

  assign s1_legal  = op_is_legal(s1_op);
  assign s1_is_cmp = (s1_op == 3'(OP_CMPGE));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    simd_lane_unit #(.LANE_W(LANE_W)) u_unit (
      .op_i(s1_op),
      .a_i(s1_a[i*LANE_W +: LANE_W]),
      .b_i(s1_b[i*LANE_W +: LANE_W]),
      .d_i(s1_d[i*LANE_W +: LANE_W]),
      .res_o(lane_res[i*LANE_W +: LANE_W]),
      .ge_o(lane_ge[i])
    );

    simd_lane_gate u_gate (
      .cond_i(s1_cond),
      .flag_i(flags[i]),
      .legal_i(s1_legal),
      .pass_o(lane_pass[i])
    );

    assign flag_upd[i] = s1_valid & s1_is_cmp & lane_pass[i];

    AST_CMP_MASK: assert property (@(posedge clk) disable iff (rst)
      (s1_valid && s1_is_cmp) |=>
        (res_o[i*LANE_W +: LANE_W] == '0 || res_o[i*LANE_W +: LANE_W] == '1)); // R3
  end

  simd_flag_bank #(.LANES(LANES)) u_flags (
    .clk(clk), .rst(rst),
    .upd_en_i(flag_upd),
    .upd_val_i(lane_ge),
    .flags_o(flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o <= 1'b0;
      lane_we_o   <= '0;
    end else begin
      res_valid_o <= s1_valid;
      lane_we_o   <= s1_valid ? lane_pass : '0;
    end
  end

  always_ff @(posedge clk) begin
    res_o <= lane_res;
  end

  AST_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (lane_we_o != '0) |-> res_valid_o); // R7

  AST_LAT_ON: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> res_valid_o); // R8

  AST_LAT_OFF: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !res_valid_o); // R8

  AST_ALWAYS_COND: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_legal && s1_cond[1]) |=> (lane_we_o == '1)); // R7

  AST_BAD_OP_NO_WE: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_legal) |=> (lane_we_o == '0 && $stable(flags))); // R9

  AST_NONCMP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    !(s1_valid && s1_is_cmp) |=> $stable(flags)); // R6

endmodule

// File: tb/sim_simd_pred_alu.sv
module sim_simd_pred_alu;

  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 8;
  localparam int LANE_W = 16;
  localparam int VEC_W  = LANES * LANE_W;

  logic             clk = 1'b0;
  logic             rst;
  logic             op_valid_i;
  logic [2:0]       op_code_i;
  logic [1:0]       cond_i;
  logic [VEC_W-1:0] src_a_i, src_b_i, dst_i;
  logic             res_valid_o;
  logic [VEC_W-1:0] res_o;
  logic [LANES-1:0] lane_we_o;

  int checks = 0;
  int errors = 0;
  logic [LANES-1:0] mflags;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_pred_alu #(.LANES(LANES), .LANE_W(LANE_W)) u0 (
    .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .op_code_i(op_code_i),
    .cond_i(cond_i), .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_i(dst_i),
    .res_valid_o(res_valid_o), .res_o(res_o), .lane_we_o(lane_we_o)
  );

  task automatic check(input string req, input logic [VEC_W-1:0] act,
                       input logic [VEC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model: computes expected outputs and advances model flags.
  task automatic model(input logic [2:0] op, input logic [1:0] cond,
                       input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                       input logic [VEC_W-1:0] d,
                       output logic [VEC_W-1:0] er, output logic [LANES-1:0] ew);
    for (int i = 0; i < LANES; i++) begin
      logic [LANE_W-1:0] ai, bi, di, ri;
      logic legal, pass;
      ai = a[i*LANE_W +: LANE_W];
      bi = b[i*LANE_W +: LANE_W];
      di = d[i*LANE_W +: LANE_W];
      case (op)
        3'd0: ri = ai + bi;
        3'd1: ri = ai - bi;
        3'd2: ri = (ai >= bi) ? '1 : '0;
        3'd3: ri = (ai & bi) | (di & ~bi);
        3'd4: ri = (ai & ~bi) | (di & bi);
        default: ri = '0;
      endcase
      legal = (op <= 3'd4);
      pass  = legal && (cond[1] || (mflags[i] == cond[0]));
      er[i*LANE_W +: LANE_W] = ri;
      ew[i] = pass;
      if (op == 3'd2 && pass) mflags[i] = (ai >= bi);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [1:0] cond,
                       input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                       input logic [VEC_W-1:0] d);
    op_valid_i = 1'b1; op_code_i = op; cond_i = cond;
    src_a_i = a; src_b_i = b; dst_i = d;
  endtask

  task automatic idle();
    op_valid_i = 1'b0;
  endtask

  // Issues one operation and checks result two edges later.
  task automatic run_op(input string req, input logic [2:0] op, input logic [1:0] cond,
                        input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                        input logic [VEC_W-1:0] d);
    logic [VEC_W-1:0] er;
    logic [LANES-1:0] ew;
    model(op, cond, a, b, d, er, ew);
    @(negedge clk); drive(op, cond, a, b, d);
    @(negedge clk); idle();
    check({req, " no early valid"}, VEC_W'(res_valid_o), '0);
    @(negedge clk);
    check({req, " valid"}, VEC_W'(res_valid_o), VEC_W'(1));
    check({req, " we"}, VEC_W'(lane_we_o), VEC_W'(ew));
    check({req, " res"}, res_o, er);
  endtask

  task automatic t_reset();
    logic [VEC_W-1:0] er; logic [LANES-1:0] ew;
    check("R10 valid after reset", VEC_W'(res_valid_o), '0);
    check("R10 we after reset", VEC_W'(lane_we_o), '0);
    // flags all zero: cond 00 passes everywhere, cond 01 nowhere
    run_op("R10 flags zero cond00", 3'd0, 2'b00, '0, '0, '0);
    run_op("R10 flags zero cond01", 3'd0, 2'b01, '0, '0, '0);
    er = '0; ew = '0;
  endtask

  task automatic t_add();
    run_op("R1 add wrap", 3'd0, 2'b10,
      {16'hFFFF,16'h0001,16'h8000,16'h1234,16'hFFFF,16'h0000,16'h7FFF,16'hABCD},
      {16'h0001,16'hFFFF,16'h8000,16'h1111,16'hFFFF,16'h0000,16'h0001,16'h0000}, '0);
  endtask

  task automatic t_sub();
    run_op("R2 sub wrap", 3'd1, 2'b11,
      {16'h0000,16'h0001,16'h8000,16'h1234,16'hFFFF,16'h0000,16'h0000,16'h5555},
      {16'h0001,16'h0002,16'h0001,16'h1234,16'h0001,16'hFFFF,16'h0000,16'h5554}, '0);
  endtask

  task automatic t_cmp();
    // equal, greater, less lanes mixed
    run_op("R3 R6 compare always", 3'd2, 2'b10,
      {16'h0005,16'h0004,16'hFFFF,16'h0000,16'h8000,16'h7FFF,16'h1000,16'h0FFF},
      {16'h0005,16'h0005,16'h0000,16'hFFFF,16'h7FFF,16'h8000,16'h1000,16'h1000}, '0);
    // flags now 10101010 (lane7..lane0): probe through add under cond 01 / 00
    run_op("R7 cond01 follows flags", 3'd0, 2'b01, '0, '1, '0);
    run_op("R7 cond00 follows inverse", 3'd0, 2'b00, '1, '1, '0);
  endtask

  task automatic t_cmp_gated();
    // compare under cond 01: only lanes with flag 1 may update; all compare false
    run_op("R6 gated compare", 3'd2, 2'b01, '0, '1, '0);
    run_op("R6 flags after gated cmp", 3'd0, 2'b01, '0, '0, '0);
  endtask

  task automatic t_insert();
    run_op("R4 insert where mask set", 3'd3, 2'b10,
      {8{16'hAAAA}}, {16'hFF00,16'h0F0F,16'hFFFF,16'h0000,16'h1234,16'h8001,16'h00FF,16'hF0F0},
      {8{16'h5555}});
    run_op("R5 insert where mask clear", 3'd4, 2'b11,
      {8{16'hAAAA}}, {16'hFF00,16'h0F0F,16'hFFFF,16'h0000,16'h1234,16'h8001,16'h00FF,16'hF0F0},
      {8{16'h5555}});
  endtask

  task automatic t_bad_op();
    run_op("R9 opcode 101", 3'd5, 2'b10, '1, '0, '1);
    run_op("R9 opcode 111", 3'd7, 2'b11, '1, '0, '1);
    run_op("R9 flags untouched", 3'd0, 2'b01, '0, '0, '0);
  endtask

  task automatic t_b2b();
    logic [VEC_W-1:0] er1, er2, a1, b1;
    logic [LANES-1:0] ew1, ew2;
    a1 = {16'h0001,16'h0000,16'h0001,16'h0000,16'h0001,16'h0000,16'h0001,16'h0000};
    b1 = {8{16'h0001}};
    model(3'd2, 2'b11, a1, b1, '0, er1, ew1);
    model(3'd1, 2'b01, {8{16'h0010}}, {8{16'h0001}}, '0, er2, ew2);
    @(negedge clk); drive(3'd2, 2'b11, a1, b1, '0);
    @(negedge clk); drive(3'd1, 2'b01, {8{16'h0010}}, {8{16'h0001}}, '0);
    @(negedge clk); idle();
    check("R8 first valid", VEC_W'(res_valid_o), VEC_W'(1));
    check("R8 first res", res_o, er1);
    check("R8 first we", VEC_W'(lane_we_o), VEC_W'(ew1));
    @(negedge clk);
    check("R8 second valid", VEC_W'(res_valid_o), VEC_W'(1));
    check("R8 second res", res_o, er2);
    check("R8 second we uses new flags", VEC_W'(lane_we_o), VEC_W'(ew2));
    @(negedge clk);
    check("R8 valid drops", VEC_W'(res_valid_o), '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; op_valid_i = 1'b0; op_code_i = '0; cond_i = '0;
    src_a_i = '0; src_b_i = '0; dst_i = '0; mflags = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_add();
    t_sub();
    t_cmp();
    t_cmp_gated();
    t_insert();
    t_bad_op();
    t_b2b();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule